// File: doc/BRIEF.md
# Multiplexed Host Bus Register Slave

This block is the register-side endpoint of a small 8-bit parallel host bus. The host reaches it through active-low chip select, write and read strobes, and one byte-wide lane that carries both addresses and data. A separate select line tells the two phases apart. When the select line is high, a write loads an internal address latch. When it is low, a read or write goes to the register the latch points at. Every completed access is confirmed by a one-cycle active-low ready pulse.

All bus pins are brought into the local clock domain through a synchroniser chain. An access is taken on the falling edge of the synchronised strobe, and only while the synchronised chip select is low. The 16-entry register space holds four kinds of register. One is an interrupt control and status register whose pending bits clear when the host reads it. One is a read-only revision register. The rest are generic storage bytes that downstream logic taps directly. One of the generic registers also drives transport-stream output enables and two active-low tuner resets. The remaining indices are unmapped.

The bus lane is split into an input, an output and an output enable, so that the pad ring can build the bidirectional pin. Two interrupt sources, synchronous to the clock, feed sticky pending bits. Any pending bit holds the active-low interrupt output asserted.

Top module: `hbus_regslave`

## Requirements
- R1: After reset the following hold until the first access: hb_rdy_n=1, hb_irq_n=1, hb_oe=0, hb_dout=0x00, all of reg_bank=0, ts_out_en=2'b00, tuner_rst_n=2'b00 (both tuners held in reset), and the address latch holds 0x00.
- R2: An access is taken only on a high-to-low transition of the synchronised write or read strobe while the synchronised hb_cs_n is low. A strobe toggled while hb_cs_n is high stores nothing and produces no ready pulse.
- R3: A write with hb_sel_addr=1 loads the whole lane byte into the address latch, and its low 4 bits select the register. A read with hb_sel_addr=1 returns the latched byte.
- R4: A write with hb_sel_addr=0 to a generic index (0x01, 0x04 to 0x0A, 0x0C, 0x0D) stores the byte in reg_bank[8*i+7:8*i]. It pulses reg_wr[i] for one cycle, in the cycle the new value first appears. A later read returns the stored byte.
- R5: Indices 0x02, 0x03, 0x0B and 0x0E read as 0x00. Writes to them change no register and pulse no reg_wr bit.
- R6: Index 0x0F always reads the REVISION parameter (default 0x5A). Writes to it change nothing.
- R7: A write to index 0x00 sets source 0's enable from lane bit 2 and source 1's enable from lane bit 6, so 0x44 enables both. A read of index 0x00 returns source 1's enable in bit 6, source 1's pending flag in bit 4, source 0's enable in bit 2 and source 0's pending flag in bit 0. All other bits read 0.
- R8: A pending bit sets on every clock edge where its source is high and enabled. A source that is disabled never sets its bit. hb_irq_n is low whenever any pending bit is set, and stays low until an acknowledging read.
- R9: A read of index 0x00 with hb_sel_addr=0 returns the pending bits as they were before the read, then clears them. A source that is high and enabled in the acknowledging cycle keeps its bit set.
- R10: Register 0x01 bits 5:4 drive ts_out_en[1:0]. Bit 3 drives tuner_rst_n[0] and bit 2 drives tuner_rst_n[1]. A cleared bit asserts that tuner's reset.
- R11: hb_rdy_n goes low for exactly one cycle after each access, whether address phase or data phase, read or write. It starts in the cycle after the clock edge that takes the access.
- R12: On a read access, hb_dout is loaded and hb_oe rises at the same edge. hb_oe stays high until the synchronised read strobe or chip select returns high. hb_dout holds its value between reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hb_cs_n | input | 1 | Bus chip select, active low |
| hb_sel_addr | input | 1 | Phase select: 1 = address phase, 0 = data phase |
| hb_wr_n | input | 1 | Write strobe, active low |
| hb_rd_n | input | 1 | Read strobe, active low |
| hb_din | input | 8 | Lane value driven by the host |
| hb_dout | output | 8 | Lane value returned on reads |
| hb_oe | output | 1 | High while the block drives the lane |
| hb_rdy_n | output | 1 | One-cycle access-complete pulse, active low |
| hb_irq_n | output | 1 | Interrupt request, active low |
| irq_src | input | N_SRC | Interrupt source levels, synchronous to clk |
| reg_bank | output | 8*2^ADDR_W | Contents of every generic register, index i at bits 8*i+7:8*i |
| reg_wr | output | 2^ADDR_W | One-cycle pulse per written generic register |
| ts_out_en | output | 2 | Transport-stream output enables |
| tuner_rst_n | output | 2 | Tuner resets, active low |

## Verification
The ready-pulse assertion relies on two accesses never being taken on adjacent clock edges. This holds whenever each strobe stays low and high for several cycles. The bench holds every strobe low for five cycles and leaves idle gaps of at least six cycles. The interrupt assertions relate hb_irq_n to irq_src, which is assumed to be synchronous to clk. Chip select and the phase line are assumed to be settled a cycle before a strobe falls. The bench sets them one cycle early and changes lane data only while the strobes are idle.

// File: rtl/hbus_pkg.sv
package hbus_pkg;
   // lane width is fixed by the bus definition
   localparam int unsigned LANE_W = 8;

   // register indices whose position other logic depends on
   localparam logic [3:0] IDX_IRQ  = 4'h0;
   localparam logic [3:0] IDX_CTL2 = 4'h1;
   localparam logic [3:0] IDX_REV  = 4'hF;

   // control-2 field positions
   localparam int unsigned TS_EN_LSB = 4;
   localparam int unsigned TUN0_BIT  = 3;
   localparam int unsigned TUN1_BIT  = 2;

   // interrupt register layout: source k enable at EN_OFS + STRIDE*k,
   // pending at STRIDE*k
   localparam int unsigned IRQ_EN_OFS = 2;
   localparam int unsigned IRQ_STRIDE = 4;
   localparam int unsigned IRQ_MAX    = 2;

   // generic storage slots: 1, 4..10, 12, 13
   localparam logic [15:0] DEF_GEN_MASK = 16'h37F2;
endpackage

// File: rtl/hbus_sync.sv
module hbus_sync #(
   parameter int unsigned    W       = 1,
   parameter int unsigned    STAGES  = 2,
   parameter logic [W-1:0]   RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("hbus_sync: STAGES must be at least 2");
   end

   logic [W-1:0] st [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) st[s] <= RST_VAL;
      end else begin
         st[0] <= d;
         for (int s = 1; s < STAGES; s++) st[s] <= st[s-1];
      end
   end

   assign q = st[STAGES-1];
endmodule

// File: rtl/hbus_front.sv
module hbus_front #(
   parameter int unsigned STAGES = 2,
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              sel,
   input  logic              wr_n,
   input  logic              rd_n,
   input  logic [DATA_W-1:0] din,
   output logic              acc_wr,
   output logic              acc_rd,
   output logic              acc_sel,
   output logic [DATA_W-1:0] acc_data,
   output logic              rd_idle
);
   localparam int unsigned CW = 4;
   // {cs_n, sel, wr_n, rd_n} idle value
   localparam logic [CW-1:0] CTL_IDLE = 4'b1011;

   logic [CW-1:0]     ctl_s;
   logic [DATA_W-1:0] din_s;
   logic              cs_s, sel_s, wr_s, rd_s;
   logic              wr_prev, rd_prev;

   hbus_sync #(.W(CW), .STAGES(STAGES), .RST_VAL(CTL_IDLE)) u_ctl_sync (
      .clk (clk),
      .rst_n (rst_n),
      .d ({cs_n, sel, wr_n, rd_n}),
      .q (ctl_s)
   );

   // lane data goes through the same depth so it lines up with the strobes
   hbus_sync #(.W(DATA_W), .STAGES(STAGES), .RST_VAL('0)) u_dat_sync (
      .clk (clk),
      .rst_n (rst_n),
      .d (din),
      .q (din_s)
   );

   assign {cs_s, sel_s, wr_s, rd_s} = ctl_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_prev <= 1'b1;
         rd_prev <= 1'b1;
      end else begin
         wr_prev <= wr_s;
         rd_prev <= rd_s;
      end
   end

   // write wins if both strobes fall together
   assign acc_wr   = wr_prev & ~wr_s & ~cs_s;
   assign acc_rd   = rd_prev & ~rd_s & ~cs_s & ~acc_wr;
   assign acc_sel  = sel_s;
   assign acc_data = din_s;
   assign rd_idle  = rd_s | cs_s;
endmodule

// File: rtl/hbus_regfile.sv
module hbus_regfile #(
   parameter int unsigned             ADDR_W   = 4,
   parameter int unsigned             DATA_W   = 8,
   parameter logic [(1<<ADDR_W)-1:0]  GEN_MASK = '0
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              wr_en,
   input  logic [ADDR_W-1:0]                 wr_idx,
   input  logic [DATA_W-1:0]                 wr_data,
   input  logic [ADDR_W-1:0]                 rd_idx,
   output logic [(1<<ADDR_W)*DATA_W-1:0]     bank,
   output logic [(1<<ADDR_W)-1:0]            wr_pulse,
   output logic [DATA_W-1:0]                 rd_data
);
   localparam int unsigned NREG = 1 << ADDR_W;

   for (genvar i = 0; i < NREG; i++) begin : g_slot
      if (GEN_MASK[i]) begin : g_store
         logic [DATA_W-1:0] q;
         logic              p;
         logic              hit;
         assign hit = wr_en && (wr_idx == ADDR_W'(i));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               q <= '0;
               p <= 1'b0;
            end else begin
               p <= hit;
               if (hit) q <= wr_data;
            end
         end
         assign bank[i*DATA_W +: DATA_W] = q;
         assign wr_pulse[i]              = p;
      end else begin : g_empty
         assign bank[i*DATA_W +: DATA_W] = '0;
         assign wr_pulse[i]              = 1'b0;
      end
   end

   assign rd_data = bank[rd_idx*DATA_W +: DATA_W];
endmodule

// File: rtl/hbus_irq.sv
module hbus_irq
   import hbus_pkg::*;
#(
   parameter int unsigned N_SRC = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ctl_wr,
   input  logic               ack,
   input  logic [N_SRC-1:0]   en_bits,
   input  logic [N_SRC-1:0]   src,
   output logic [N_SRC-1:0]   pend,
   output logic [LANE_W-1:0]  rd_word
);
   if (N_SRC < 1 || N_SRC > IRQ_MAX) begin : g_bad_src
      $error("hbus_irq: N_SRC out of range");
   end

   logic [N_SRC-1:0] en_q;
   logic [N_SRC-1:0] pend_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= '0;
         pend_q <= '0;
      end else begin
         if (ctl_wr) en_q <= en_bits;
         for (int k = 0; k < N_SRC; k++) begin
            // a live source beats the acknowledge
            if (src[k] && en_q[k])  pend_q[k] <= 1'b1;
            else if (ack)           pend_q[k] <= 1'b0;
         end
      end
   end

   always_comb begin
      rd_word = '0;
      for (int k = 0; k < N_SRC; k++) begin
         rd_word[IRQ_EN_OFS + IRQ_STRIDE*k] = en_q[k];
         rd_word[IRQ_STRIDE*k]              = pend_q[k];
      end
   end

   assign pend = pend_q;
endmodule

// File: rtl/hbus_regslave.sv
module hbus_regslave
   import hbus_pkg::*;
#(
   parameter int unsigned             ADDR_W      = 4,
   parameter int unsigned             SYNC_STAGES = 2,
   parameter int unsigned             N_SRC       = 2,
   parameter logic [LANE_W-1:0]       REVISION    = 8'h5A,
   parameter logic [(1<<ADDR_W)-1:0]  GEN_MASK    = DEF_GEN_MASK
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              hb_cs_n,
   input  logic                              hb_sel_addr,
   input  logic                              hb_wr_n,
   input  logic                              hb_rd_n,
   input  logic [LANE_W-1:0]                 hb_din,
   output logic [LANE_W-1:0]                 hb_dout,
   output logic                              hb_oe,
   output logic                              hb_rdy_n,
   output logic                              hb_irq_n,
   input  logic [N_SRC-1:0]                  irq_src,
   output logic [(1<<ADDR_W)*LANE_W-1:0]     reg_bank,
   output logic [(1<<ADDR_W)-1:0]            reg_wr,
   output logic [1:0]                        ts_out_en,
   output logic [1:0]                        tuner_rst_n
);
   localparam int unsigned CTL2_LSB = int'(IDX_CTL2) * LANE_W;

   if (ADDR_W < 4 || ADDR_W > LANE_W) begin : g_bad_aw
      $error("hbus_regslave: ADDR_W must lie in 4..8");
   end
   if (GEN_MASK[IDX_IRQ] || GEN_MASK[IDX_REV]) begin : g_bad_mask
      $error("hbus_regslave: GEN_MASK overlaps a dedicated register");
   end
   if (!GEN_MASK[IDX_CTL2]) begin : g_bad_ctl2
      $error("hbus_regslave: control-2 slot must be generic storage");
   end

   // bus front end
   logic              acc_wr, acc_rd, acc_sel, rd_idle;
   logic [LANE_W-1:0] acc_data;

   hbus_front #(.STAGES(SYNC_STAGES), .DATA_W(LANE_W)) u_front (
      .clk (clk),
      .rst_n (rst_n),
      .cs_n (hb_cs_n),
      .sel (hb_sel_addr),
      .wr_n (hb_wr_n),
      .rd_n (hb_rd_n),
      .din (hb_din),
      .acc_wr (acc_wr),
      .acc_rd (acc_rd),
      .acc_sel (acc_sel),
      .acc_data (acc_data),
      .rd_idle (rd_idle)
   );

   // address latch
   logic [LANE_W-1:0] addr_q;
   logic [ADDR_W-1:0] cur_idx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 addr_q <= '0;
      else if (acc_wr && acc_sel) addr_q <= acc_data;
   end

   assign cur_idx = addr_q[ADDR_W-1:0];

   logic data_wr, data_rd;
   assign data_wr = acc_wr & ~acc_sel;
   assign data_rd = acc_rd & ~acc_sel;

   // generic storage
   logic [LANE_W-1:0] gen_rdata;

   hbus_regfile #(.ADDR_W(ADDR_W), .DATA_W(LANE_W), .GEN_MASK(GEN_MASK)) u_regs (
      .clk (clk),
      .rst_n (rst_n),
      .wr_en (data_wr),
      .wr_idx (cur_idx),
      .wr_data (acc_data),
      .rd_idx (cur_idx),
      .bank (reg_bank),
      .wr_pulse (reg_wr),
      .rd_data (gen_rdata)
   );

   // interrupt control
   logic [N_SRC-1:0]  en_bits;
   logic [N_SRC-1:0]  pend;
   logic [LANE_W-1:0] irq_word;
   logic              at_irq, at_rev;

   assign at_irq = (cur_idx == ADDR_W'(IDX_IRQ));
   assign at_rev = (cur_idx == ADDR_W'(IDX_REV));

   for (genvar k = 0; k < N_SRC; k++) begin : g_en
      assign en_bits[k] = acc_data[IRQ_EN_OFS + IRQ_STRIDE*k];
   end

   hbus_irq #(.N_SRC(N_SRC)) u_irq (
      .clk (clk),
      .rst_n (rst_n),
      .ctl_wr (data_wr && at_irq),
      .ack (data_rd && at_irq),
      .en_bits (en_bits),
      .src (irq_src),
      .pend (pend),
      .rd_word (irq_word)
   );

   assign hb_irq_n = ~(|pend);

   // read return
   logic [LANE_W-1:0] rsel;

   always_comb begin
      if (acc_sel)     rsel = addr_q;
      else if (at_irq) rsel = irq_word;
      else if (at_rev) rsel = REVISION;
      else             rsel = gen_rdata;
   end

   logic [LANE_W-1:0] dout_q;
   logic              oe_q, rdy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dout_q <= '0;
         oe_q   <= 1'b0;
         rdy_q  <= 1'b1;
      end else begin
         rdy_q <= ~(acc_wr | acc_rd);
         if (acc_rd) begin
            dout_q <= rsel;
            oe_q   <= 1'b1;
         end else if (rd_idle) begin
            oe_q   <= 1'b0;
         end
      end
   end

   assign hb_dout  = dout_q;
   assign hb_oe    = oe_q;
   assign hb_rdy_n = rdy_q;

   // control-2 taps
   assign ts_out_en      = reg_bank[CTL2_LSB + TS_EN_LSB +: 2];
   assign tuner_rst_n[0] = reg_bank[CTL2_LSB + TUN0_BIT];
   assign tuner_rst_n[1] = reg_bank[CTL2_LSB + TUN1_BIT];
endmodule

// File: rtl/hbus_regslave_chk.sv
module hbus_regslave_chk #(
   parameter int unsigned        ADDR_W   = 4,
   parameter int unsigned        N_SRC    = 2,
   parameter logic [7:0]         REVISION = 8'h5A
) (
   input logic                          clk,
   input logic                          rst_n,
   input logic                          hb_rdy_n,
   input logic                          hb_irq_n,
   input logic [7:0]                    hb_dout,
   input logic [N_SRC-1:0]              irq_src,
   input logic [(1<<ADDR_W)*8-1:0]      reg_bank,
   input logic [(1<<ADDR_W)-1:0]        reg_wr,
   input logic [1:0]                    ts_out_en,
   input logic [1:0]                    tuner_rst_n,
   input logic                          acc_wr,
   input logic                          acc_rd,
   input logic                          acc_sel,
   input logic [ADDR_W-1:0]             cur_idx
);
   // R11: the ready pulse lasts a single cycle
   a_r11_rdy_single: assert property (@(posedge clk) disable iff (!rst_n)
      !hb_rdy_n |=> hb_rdy_n);

   // R11: each taken access is followed by a ready pulse
   a_r11_rdy_follows: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_wr || acc_rd) |=> !hb_rdy_n);

   // R6: the revision slot always returns the parameter
   a_r6_rev_read: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_rd && !acc_sel && cur_idx == ADDR_W'(15)) |=> (hb_dout == REVISION));

   // R8: interrupt holds until the acknowledging read
   a_r8_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (!hb_irq_n && !(acc_rd && !acc_sel && cur_idx == ADDR_W'(0))) |=> !hb_irq_n);

   // R8: interrupt only rises after a source was active
   a_r8_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(hb_irq_n) |-> $past(|irq_src));

   // R5: storage only changes alongside a write pulse
   a_r5_bank_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr == '0) |-> $stable(reg_bank));

   // R4: at most one register written per access
   a_r4_onehot_wr: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(reg_wr));

   // R10: stream enables and tuner resets move only on a control-2 write
   a_r10_ctl_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !(acc_wr && !acc_sel && cur_idx == ADDR_W'(1))
      |=> ($stable(ts_out_en) && $stable(tuner_rst_n)));
endmodule

bind hbus_regslave hbus_regslave_chk #(
   .ADDR_W (ADDR_W),
   .N_SRC (N_SRC),
   .REVISION (REVISION)
) u_chk (
   .clk (clk),
   .rst_n (rst_n),
   .hb_rdy_n (hb_rdy_n),
   .hb_irq_n (hb_irq_n),
   .hb_dout (hb_dout),
   .irq_src (irq_src),
   .reg_bank (reg_bank),
   .reg_wr (reg_wr),
   .ts_out_en (ts_out_en),
   .tuner_rst_n (tuner_rst_n),
   .acc_wr (acc_wr),
   .acc_rd (acc_rd),
   .acc_sel (acc_sel),
   .cur_idx (cur_idx)
);

// File: tb/hbus_regslave_tb.sv
module hbus_regslave_tb;
   localparam logic [7:0] REV = 8'h5A;

   logic         clk = 1'b0;
   logic         rst_n;
   logic         hb_cs_n, hb_sel_addr, hb_wr_n, hb_rd_n;
   logic [7:0]   hb_din, hb_dout;
   logic         hb_oe, hb_rdy_n, hb_irq_n;
   logic [1:0]   irq_src;
   logic [127:0] reg_bank;
   logic [15:0]  reg_wr;
   logic [1:0]   ts_out_en, tuner_rst_n;

   always #2 clk = ~clk;

   hbus_regslave #(.REVISION(REV)) u_dut (
      .clk (clk), .rst_n (rst_n),
      .hb_cs_n (hb_cs_n), .hb_sel_addr (hb_sel_addr),
      .hb_wr_n (hb_wr_n), .hb_rd_n (hb_rd_n),
      .hb_din (hb_din), .hb_dout (hb_dout), .hb_oe (hb_oe),
      .hb_rdy_n (hb_rdy_n), .hb_irq_n (hb_irq_n), .irq_src (irq_src),
      .reg_bank (reg_bank), .reg_wr (reg_wr),
      .ts_out_en (ts_out_en), .tuner_rst_n (tuner_rst_n)
   );

   int n_chk = 0;
   int n_fail = 0;

   // reference model
   logic [7:0] m_reg [16];
   logic [7:0] m_addr;
   logic [1:0] m_en, m_pend;

   task automatic check_eq(input string req, input logic [127:0] act, input logic [127:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   function automatic bit is_gen(input int i);
      return (i == 1) || (i >= 4 && i <= 10) || (i == 12) || (i == 13);
   endfunction

   function automatic logic [7:0] exp_rd(input logic [3:0] i);
      if (i == 4'h0)  return {1'b0, m_en[1], 1'b0, m_pend[1], 1'b0, m_en[0], 1'b0, m_pend[0]};
      if (i == 4'hF)  return REV;
      if (is_gen(int'(i))) return m_reg[i];
      return 8'h00;
   endfunction

   function automatic logic [127:0] exp_bank();
      logic [127:0] v = '0;
      for (int i = 0; i < 16; i++) if (is_gen(i)) v[i*8 +: 8] = m_reg[i];
      return v;
   endfunction

   task automatic bus_op(input bit is_wr, input bit sel, input logic [7:0] d, input bit use_cs,
                         output logic [7:0] rd, output int lows, output logic [15:0] wseen,
                         output bit oe_mid, output bit oe_end);
      @(negedge clk);
      hb_cs_n = !use_cs; hb_sel_addr = sel; hb_din = d;
      @(negedge clk);
      if (is_wr) hb_wr_n = 1'b0; else hb_rd_n = 1'b0;
      lows = 0; wseen = '0;
      for (int c = 0; c < 5; c++) begin
         @(negedge clk);
         if (!hb_rdy_n) lows++;
         wseen |= reg_wr;
      end
      rd = hb_dout; oe_mid = hb_oe;
      hb_wr_n = 1'b1; hb_rd_n = 1'b1;
      for (int c = 0; c < 3; c++) begin
         @(negedge clk);
         if (!hb_rdy_n) lows++;
         wseen |= reg_wr;
      end
      hb_cs_n = 1'b1;
      for (int c = 0; c < 3; c++) begin
         @(negedge clk);
         if (!hb_rdy_n) lows++;
      end
      oe_end = hb_oe;
   endtask

   task automatic do_addr_wr(input logic [7:0] b);
      logic [7:0] rd; int lows; logic [15:0] ws; bit om, oend;
      bus_op(1'b1, 1'b1, b, 1'b1, rd, lows, ws, om, oend);
      m_addr = b;
      check_eq("R11 ready after address write", lows, 1);
      check_eq("R3 address write pulses no register", ws, 0);
   endtask

   task automatic do_addr_rd();
      logic [7:0] rd; int lows; logic [15:0] ws; bit om, oend;
      bus_op(1'b0, 1'b1, 8'h00, 1'b1, rd, lows, ws, om, oend);
      check_eq("R3 address readback", rd, m_addr);
      check_eq("R11 ready after address read", lows, 1);
   endtask

   task automatic do_data_wr(input logic [7:0] d);
      logic [7:0] rd; int lows; logic [15:0] ws; bit om, oend;
      logic [3:0] i = m_addr[3:0];
      logic [15:0] exp_ws;
      bus_op(1'b1, 1'b0, d, 1'b1, rd, lows, ws, om, oend);
      exp_ws = is_gen(int'(i)) ? (16'h1 << i) : 16'h0;
      if (is_gen(int'(i))) m_reg[i] = d;
      if (i == 4'h0) m_en = {d[6], d[2]};
      check_eq(is_gen(int'(i)) ? "R4 write pulse" : "R5 no write pulse", ws, exp_ws);
      check_eq(is_gen(int'(i)) ? "R4 tapped storage" : "R5 storage untouched", reg_bank, exp_bank());
      check_eq("R10 stream enables", ts_out_en, m_reg[1][5:4]);
      check_eq("R10 tuner resets", tuner_rst_n, {m_reg[1][2], m_reg[1][3]});
      check_eq("R11 ready after data write", lows, 1);
   endtask

   task automatic do_data_rd();
      logic [7:0] rd; int lows; logic [15:0] ws; bit om, oend;
      logic [3:0] i = m_addr[3:0];
      logic [7:0] e;
      m_pend = m_pend | (irq_src & m_en);
      e = exp_rd(i);
      bus_op(1'b0, 1'b0, 8'h00, 1'b1, rd, lows, ws, om, oend);
      if (i == 4'h0)      check_eq("R7 interrupt register read", rd, e);
      else if (i == 4'hF) check_eq("R6 revision read", rd, e);
      else if (is_gen(int'(i))) check_eq("R4 generic readback", rd, e);
      else                check_eq("R5 unmapped reads zero", rd, e);
      check_eq("R12 lane driven during read", om, 1);
      check_eq("R12 lane released after read", oend, 0);
      check_eq("R11 ready after data read", lows, 1);
      if (i == 4'h0) m_pend = irq_src & m_en;
      check_eq("R9 interrupt after acknowledge", hb_irq_n, !(|m_pend));
   endtask

   task automatic irq_pulse(input logic [1:0] v);
      @(negedge clk); irq_src = v;
      @(negedge clk); irq_src = 2'b00;
      m_pend = m_pend | (v & m_en);
      check_eq("R8 interrupt level", hb_irq_n, !(|m_pend));
   endtask

   // watchdog
   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      for (int i = 0; i < 16; i++) m_reg[i] = 8'h00;
      m_addr = 8'h00; m_en = 2'b00; m_pend = 2'b00;
      rst_n = 1'b0; hb_cs_n = 1'b1; hb_sel_addr = 1'b0;
      hb_wr_n = 1'b1; hb_rd_n = 1'b1; hb_din = 8'h00; irq_src = 2'b00;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check_eq("R1 ready idle", hb_rdy_n, 1);
      check_eq("R1 interrupt idle", hb_irq_n, 1);
      check_eq("R1 lane not driven", hb_oe, 0);
      check_eq("R1 dout zero", hb_dout, 0);
      check_eq("R1 storage zero", reg_bank, 0);
      check_eq("R1 stream enables off", ts_out_en, 0);
      check_eq("R1 tuners held in reset", tuner_rst_n, 0);
      do_addr_rd();

      // R6 revision, write ignored
      do_addr_wr(8'h0F);
      do_data_rd();
      do_data_wr(8'hFF);
      do_data_rd();

      // R10 control-2 fields
      do_addr_wr(8'h01);
      do_data_wr(8'h3C);
      do_data_wr(8'h14);
      do_data_rd();

      // R5 unmapped slot
      do_addr_wr(8'h0B);
      do_data_wr(8'h77);
      do_data_rd();

      // R3 upper latch bits kept, low nibble selects
      do_addr_wr(8'hE4);
      do_data_wr(8'h99);
      do_data_rd();
      do_addr_rd();

      // R2 strobe while deselected is ignored
      begin
         logic [7:0] rd; int lows; logic [15:0] ws; bit om, oend;
         bus_op(1'b1, 1'b0, 8'h11, 1'b0, rd, lows, ws, om, oend);
         check_eq("R2 no ready when deselected", lows, 0);
         check_eq("R2 no store when deselected", reg_bank, exp_bank());
      end
      do_data_rd();

      // R8 disabled sources do nothing
      irq_pulse(2'b11);
      do_addr_wr(8'h00);
      do_data_wr(8'h44);
      do_data_rd();
      irq_pulse(2'b01);
      repeat (6) @(negedge clk);
      check_eq("R8 interrupt sticky", hb_irq_n, 0);
      do_data_rd();
      irq_pulse(2'b10);
      do_data_rd();

      // R9 live source survives acknowledge
      @(negedge clk); irq_src = 2'b01;
      do_data_rd();
      check_eq("R9 live source keeps request", hb_irq_n, 0);
      @(negedge clk); irq_src = 2'b00;
      do_data_rd();
      check_eq("R9 cleared once source drops", hb_irq_n, 1);

      // random mix
      for (int n = 0; n < 400; n++) begin
         int op = int'($urandom % 6);
         case (op)
            0: do_addr_wr(8'($urandom));
            1: do_data_wr(8'($urandom));
            2: do_data_rd();
            3: do_addr_rd();
            4: irq_pulse(2'($urandom));
            default: begin
               do_addr_wr({4'($urandom), 4'h0});
               do_data_wr(8'($urandom));
            end
         endcase
      end

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule